// File: doc/BRIEF.md
# Pad Configuration and Ownership Controller

This block sits beside one I/O pad and holds the 13-bit word that sets up the pad's static behaviour. It also decides who drives the pad's three dynamic signals: pad output value, active-low output enable, and pad input. Configuration arrives in two steps. A bus-side write puts a word into a staging register. A separate transfer strobe later copies that word into the active register, and only the active register steers the pad. This lets many pads be reprogrammed and then switched over together.

The active word's bit 0 gives the pad either to the user logic or to the management side. A build-time parameter picks the shape of the management connection. In the full form, management has its own output, output-enable and input signals. In the single-wire form, management has one wire, and configuration bit 1 sets its direction: it either carries the pad input to management or carries management's value out to the pad. When the digital mode field holds one of the two pull-up or pull-down input codes, the block drives the pad output value itself, so that the pad cell sees the level the pull needs.

Top module: `pad_ctl_unit`

## Requirements
- R1: A synchronous active-low reset loads the default word into both the staging and the active register. The default is 13'h403 in single-wire form (mode 001, bit 1 = 1, bit 0 = 1) and 13'h1801 in full form (mode 110, bit 1 = 0, bit 0 = 1).
- R2: A write (`cfg_we` high at a clock edge) loads `cfg_wdata` into the staging register only. `cfg_q` and the pad signals do not change until a transfer.
- R3: A transfer (`cfg_xfer` high at a clock edge) copies the staging register to the active register at that edge. If a write and a transfer occur in the same cycle, the transfer copies the staged value from before the write.
- R4: With active bit 0 = 0 and the mode not a pull code: `pad_out` = `user_out`, `pad_oeb` = `user_oeb`, and `mgmt_in` = 0.
- R5: `user_in` always equals `pad_in`, whatever the configuration.
- R6: In full form with bit 0 = 1: `pad_out` = `mgmt_out`, `pad_oeb` = `mgmt_oeb`, and `mgmt_in` = `pad_in`. Bit 1 is ignored.
- R7: In single-wire form with bit 0 = 1 and bit 1 = 1, the wire reads the pad: `pad_oeb` = 1, `mgmt_in` = `pad_in`, and `pad_out` = 0 unless R9 applies.
- R8: In single-wire form with bit 0 = 1 and bit 1 = 0, the wire drives the pad: `pad_oeb` = 0, `pad_out` = `mgmt_out`, and `mgmt_in` = 0.
- R9: When the mode field (bits 12:10) is 010 or 011, `pad_out` equals the inverse of mode bit 10. That is 1 for code 010 (pull-up) and 0 for code 011 (pull-down), whichever side owns the pad.
- R10: `cfg_q` presents the active word. Bits 9:2 are passed to the pad cell and have no effect on the routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Stage-write strobe |
| cfg_wdata | input | 13 | Word to stage |
| cfg_xfer | input | 1 | Transfer strobe, staging to active |
| cfg_q | output | 13 | Active configuration word to the pad cell |
| pad_in | input | 1 | Value read from the pad |
| pad_out | output | 1 | Value driven toward the pad |
| pad_oeb | output | 1 | Pad output enable, active low |
| user_out | input | 1 | User output value |
| user_oeb | input | 1 | User output enable, active low |
| user_in | output | 1 | Pad input seen by the user |
| mgmt_out | input | 1 | Management output value, or the outbound side of the single wire |
| mgmt_oeb | input | 1 | Management output enable, active low; used only in full form |
| mgmt_in | output | 1 | Pad input seen by management, or the inbound side of the single wire |

## Verification
A fault in the staging or active register appears on `cfg_q` at the first clock edge after the write, transfer or reset that exposes it. Because the routing is purely combinational from the active word, it also changes `pad_oeb`, `pad_out` or `mgmt_in` in that same cycle. A staged value that is lost or corrupted stays hidden until the next transfer, so the bench always follows a staged-only write with a transfer. A misrouted ownership or direction bit appears at once as a wrong driver on the pad pins, or as a nonzero `mgmt_in` while the pad belongs to the user.

// File: rtl/pad_ctl_pkg.sv
package pad_ctl_pkg;

    localparam int CFG_W  = 13;
    localparam int MODE_W = 3;

    // Field order is fixed: the pad cell decodes these positions.
    typedef struct packed {
        logic [MODE_W-1:0] dmode;     // 12:10
        logic              vtrip;     // 9
        logic              slew;      // 8
        logic              ana_pol;   // 7
        logic              ana_sel;   // 6
        logic              ana_en;    // 5
        logic              ib_sel;    // 4
        logic              in_dis;    // 3
        logic              hold;      // 2
        logic              out_dis;   // 1
        logic              mgmt_own;  // 0
    } pad_cfg_t;

    localparam logic [MODE_W-1:0] MODE_PULLUP = 3'b010;
    localparam logic [MODE_W-1:0] MODE_PULLDN = 3'b011;

    function automatic logic [CFG_W-1:0] default_word(input bit full_mgmt);
        pad_cfg_t c;
        c          = '0;
        c.mgmt_own = 1'b1;
        if (full_mgmt) begin
            c.dmode   = 3'b110;
            c.out_dis = 1'b0;
        end else begin
            c.dmode   = 3'b001;
            c.out_dis = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/pad_cfg_regs.sv
module pad_cfg_regs
    import pad_ctl_pkg::*;
#(
    parameter logic [CFG_W-1:0] RST_WORD = 13'h403
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             xfer,
    output pad_cfg_t         active
);

    typedef struct packed {
        pad_cfg_t stage;
        pad_cfg_t act;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Transfer reads the stage value from before this cycle's write.
        if (xfer) begin
            st_d.act = st_q.stage;
        end
        if (we) begin
            st_d.stage = pad_cfg_t'(wdata);
        end
        if (!rst_n) begin
            st_d.stage = pad_cfg_t'(RST_WORD);
            st_d.act   = pad_cfg_t'(RST_WORD);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign active = st_q.act;

endmodule

// File: rtl/pad_route.sv
module pad_route
    import pad_ctl_pkg::*;
#(
    parameter bit FULL_MGMT = 1'b0
) (
    input  logic              own_mgmt,
    input  logic              out_dis,
    input  logic [MODE_W-1:0] dmode,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oeb,
    input  logic              user_out,
    input  logic              user_oeb,
    output logic              user_in,
    input  logic              mgmt_out,
    input  logic              mgmt_oeb,
    output logic              mgmt_in
);

    logic m_out, m_oeb, m_in;
    logic pull_mode;
    logic base_out;

    generate
        if (FULL_MGMT) begin : g_full
            logic unused_dis;
            assign unused_dis = out_dis;
            always_comb begin
                m_out = mgmt_out;
                m_oeb = mgmt_oeb;
                m_in  = pad_in;
            end
        end else begin : g_wire
            logic unused_oeb;
            assign unused_oeb = mgmt_oeb;
            always_comb begin
                if (out_dis) begin
                    m_out = 1'b0;
                    m_oeb = 1'b1;
                    m_in  = pad_in;
                end else begin
                    m_out = mgmt_out;
                    m_oeb = 1'b0;
                    m_in  = 1'b0;
                end
            end
        end
    endgenerate

    always_comb begin
        pull_mode = (dmode == MODE_PULLUP) || (dmode == MODE_PULLDN);
        base_out  = own_mgmt ? m_out : user_out;
        pad_oeb   = own_mgmt ? m_oeb : user_oeb;
        mgmt_in   = own_mgmt ? m_in  : 1'b0;
        pad_out   = pull_mode ? ~dmode[0] : base_out;
        user_in   = pad_in;
    end

endmodule

// File: rtl/pad_ctl_unit.sv
module pad_ctl_unit
    import pad_ctl_pkg::*;
#(
    parameter bit FULL_MGMT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cfg_xfer,
    output logic [CFG_W-1:0] cfg_q,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oeb,
    input  logic             user_out,
    input  logic             user_oeb,
    output logic             user_in,
    input  logic             mgmt_out,
    input  logic             mgmt_oeb,
    output logic             mgmt_in
);

    localparam logic [CFG_W-1:0] RST_WORD = default_word(FULL_MGMT);

    pad_cfg_t act;

    pad_cfg_regs #(.RST_WORD(RST_WORD)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .xfer   (cfg_xfer),
        .active (act)
    );

    pad_route #(.FULL_MGMT(FULL_MGMT)) route_i (
        .own_mgmt (act.mgmt_own),
        .out_dis  (act.out_dis),
        .dmode    (act.dmode),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oeb  (pad_oeb),
        .user_out (user_out),
        .user_oeb (user_oeb),
        .user_in  (user_in),
        .mgmt_out (mgmt_out),
        .mgmt_oeb (mgmt_oeb),
        .mgmt_in  (mgmt_in)
    );

    assign cfg_q = act;

endmodule

// File: rtl/pad_ctl_unit_chk.sv
module pad_ctl_unit_chk
    import pad_ctl_pkg::*;
#(
    parameter bit FULL_MGMT = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             cfg_xfer,
    input logic [CFG_W-1:0] cfg_q,
    input logic             pad_in,
    input logic             pad_out,
    input logic             pad_oeb,
    input logic             user_out,
    input logic             user_oeb,
    input logic             user_in,
    input logic             mgmt_out,
    input logic             mgmt_oeb,
    input logic             mgmt_in
);

    localparam logic [CFG_W-1:0] RST_WORD = default_word(FULL_MGMT);

    logic pull;
    assign pull = (cfg_q[12:10] == MODE_PULLUP) || (cfg_q[12:10] == MODE_PULLDN);

    p_reset_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_q == RST_WORD);

    p_hold_no_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_xfer |=> $stable(cfg_q));

    p_stage_then_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we ##1 (cfg_xfer && !cfg_we) |=> cfg_q == $past(cfg_wdata, 2));

    p_user_owns_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[0] && !pull) |-> (pad_out == user_out && pad_oeb == user_oeb && !mgmt_in));

    p_user_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        user_in == pad_in);

    p_pull_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pull |-> pad_out == ~cfg_q[10]);

    generate
        if (FULL_MGMT) begin : g_full
            p_full_mgmt_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[0] && !pull) |-> (pad_out == mgmt_out && pad_oeb == mgmt_oeb && mgmt_in == pad_in));
        end else begin : g_wire
            p_wire_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[0] && cfg_q[1]) |-> (pad_oeb && mgmt_in == pad_in));
            p_wire_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[0] && !cfg_q[1] && !pull) |-> (!pad_oeb && pad_out == mgmt_out && !mgmt_in));
        end
    endgenerate

endmodule

bind pad_ctl_unit pad_ctl_unit_chk #(.FULL_MGMT(FULL_MGMT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_xfer  (cfg_xfer),
    .cfg_q     (cfg_q),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oeb   (pad_oeb),
    .user_out  (user_out),
    .user_oeb  (user_oeb),
    .user_in   (user_in),
    .mgmt_out  (mgmt_out),
    .mgmt_oeb  (mgmt_oeb),
    .mgmt_in   (mgmt_in)
);

// File: tb/pad_ctl_unit_tb_top.sv
`timescale 1ns/1ps
module pad_ctl_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [12:0] cfg_wdata = '0;
    logic        cfg_xfer = 1'b0;
    logic        pad_in = 1'b0, user_out = 1'b0, user_oeb = 1'b1;
    logic        mgmt_out = 1'b0, mgmt_oeb = 1'b1;

    logic [12:0] s_cfg, f_cfg;
    logic s_po, s_poe, s_ui, s_mi;
    logic f_po, f_poe, f_ui, f_mi;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pad_ctl_unit #(.FULL_MGMT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_xfer(cfg_xfer), .cfg_q(s_cfg), .pad_in(pad_in), .pad_out(s_po),
        .pad_oeb(s_poe), .user_out(user_out), .user_oeb(user_oeb), .user_in(s_ui),
        .mgmt_out(mgmt_out), .mgmt_oeb(mgmt_oeb), .mgmt_in(s_mi));

    pad_ctl_unit #(.FULL_MGMT(1'b1)) dut_full_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_xfer(cfg_xfer), .cfg_q(f_cfg), .pad_in(pad_in), .pad_out(f_po),
        .pad_oeb(f_poe), .user_out(user_out), .user_oeb(user_oeb), .user_in(f_ui),
        .mgmt_out(mgmt_out), .mgmt_oeb(mgmt_oeb), .mgmt_in(f_mi));

    typedef struct packed {
        logic [3:0]  rid;
        logic [12:0] cfg;
        logic        uo, uoe, mo, moe, pin;
        logic        s_po, s_poe, s_mi;
        logic        f_po, f_poe, f_mi;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{4'd4, 13'h402, 1'b1,1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R4 user drives
        '{4'd4, 13'h402, 1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0, 1'b0,1'b1,1'b0}, // R4 user tristate
        '{4'd7, 13'h403, 1'b1,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b1,1'b0,1'b1}, // R7 wire reads, R6 full
        '{4'd8, 13'h401, 1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0}, // R8 wire drives 1, R6 ignores bit1
        '{4'd8, 13'h401, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1}, // R8 wire drives 0
        '{4'd9, 13'h803, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0, 1'b1,1'b1,1'b0}, // R9 pull-up, mgmt
        '{4'd9, 13'hC03, 1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b0,1'b0,1'b1}, // R9 pull-down, mgmt
        '{4'd9, 13'h802, 1'b0,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0, 1'b1,1'b1,1'b0}, // R9 pull-up, user
        '{4'd6, 13'h1801,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1}, // R6 full, R8 wire
        '{4'd10,13'h7FB, 1'b1,1'b1,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b0,1'b0,1'b1}  // R10 side bits set
    };

    function automatic string rname(input int id);
        case (id)
            1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
            9: return "R9";  default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_cfg(input logic [12:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        tick();
        cfg_we = 1'b0; cfg_xfer = 1'b1;
        tick();
        cfg_xfer = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        pad_in = 1'b1; mgmt_out = 1'b1;
        tick(); tick();
        chk("R1", "wire reset cfg", s_cfg, 13'h403);
        chk("R1", "full reset cfg", f_cfg, 13'h1801);
        chk("R7", "reset wire oeb", {12'd0, s_poe}, 13'd1);
        chk("R7", "reset wire mgmt_in", {12'd0, s_mi}, 13'd1);
        rst_n = 1'b1;
        cfg_xfer = 1'b1; tick(); cfg_xfer = 1'b0;
        chk("R1", "staged default wire", s_cfg, 13'h403);
        chk("R1", "staged default full", f_cfg, 13'h1801);

        for (int i = 0; i < NV; i++) begin
            load_cfg(VEC[i].cfg);
            user_out = VEC[i].uo; user_oeb = VEC[i].uoe;
            mgmt_out = VEC[i].mo; mgmt_oeb = VEC[i].moe; pad_in = VEC[i].pin;
            #1;
            chk(rname(int'(VEC[i].rid)), "wire pad_out", {12'd0, s_po},  {12'd0, VEC[i].s_po});
            chk(rname(int'(VEC[i].rid)), "wire pad_oeb", {12'd0, s_poe}, {12'd0, VEC[i].s_poe});
            chk(rname(int'(VEC[i].rid)), "wire mgmt_in", {12'd0, s_mi},  {12'd0, VEC[i].s_mi});
            chk(rname(int'(VEC[i].rid)), "full pad_out", {12'd0, f_po},  {12'd0, VEC[i].f_po});
            chk(rname(int'(VEC[i].rid)), "full pad_oeb", {12'd0, f_poe}, {12'd0, VEC[i].f_poe});
            chk(rname(int'(VEC[i].rid)), "full mgmt_in", {12'd0, f_mi},  {12'd0, VEC[i].f_mi});
            chk("R5", "user_in wire", {12'd0, s_ui}, {12'd0, VEC[i].pin});
            chk("R5", "user_in full", {12'd0, f_ui}, {12'd0, VEC[i].pin});
            chk("R10", "active word", s_cfg, VEC[i].cfg);
        end

        // R2: a write without transfer leaves the pad under user control
        load_cfg(13'h402);
        user_out = 1'b1; user_oeb = 1'b0;
        cfg_we = 1'b1; cfg_wdata = 13'h403;
        tick(); cfg_we = 1'b0;
        tick(); tick();
        chk("R2", "cfg after stage only", s_cfg, 13'h402);
        chk("R2", "pad_oeb after stage only", {12'd0, s_poe}, 13'd0);
        chk("R2", "pad_out after stage only", {12'd0, s_po}, 13'd1);

        // R3: write and transfer together move the older staged word
        cfg_we = 1'b1; cfg_wdata = 13'h801; cfg_xfer = 1'b1;
        tick();
        cfg_we = 1'b0; cfg_xfer = 1'b0;
        chk("R3", "same-cycle xfer takes old stage", s_cfg, 13'h403);
        cfg_xfer = 1'b1; tick(); cfg_xfer = 1'b0;
        chk("R3", "later xfer takes new stage", s_cfg, 13'h801);
        chk("R9", "pull-up forced after xfer", {12'd0, s_po}, 13'd1);

        // R1: reset in mid-run restores both registers
        cfg_we = 1'b1; cfg_wdata = 13'h000; tick(); cfg_we = 1'b0;
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk("R1", "mid-run reset wire", s_cfg, 13'h403);
        chk("R1", "mid-run reset full", f_cfg, 13'h1801);
        cfg_xfer = 1'b1; tick(); cfg_xfer = 1'b0;
        chk("R1", "stage cleared by reset", s_cfg, 13'h403);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule